// File: doc/BRIEF.md
# Round-Robin Event Builder Selector

For every accepted trigger this block names the event builder, one of up to sixteen, that receives the event's data. An enable mask lists the builders that take part. The block steps through the enabled builders in ascending index order and wraps back to the lowest one. A group length keeps a builder selected for a set number of consecutive events before the selection moves on. This lets many small events be packed into one large transfer.

Triggers of the calibration type can be sent to one fixed builder. This routing is switched on by a separate enable and leaves the rotation untouched. When the enable is off, calibration triggers are handled like any other event.

The chosen index is registered. It appears one clock after the accept strobe, together with a one-cycle valid pulse, and it holds its value until the next accepted event. Event transport and builder back-pressure are handled elsewhere.

Top module: `eb_rr_select`

## Requirements
- R1: While reset is active, and after it is released, `eb_idx_o` is 0 and `eb_vld_o` is 0.
- R2: Each cycle with `evt_accept_i` high gives exactly one `eb_vld_o` pulse in the following cycle. Without an accept, `eb_vld_o` stays low and `eb_idx_o` keeps its value.
- R3: The first normal event after reset takes the lowest-index set bit of `cfg_mask_i` (bit k enables builder k). Later picks take the next higher enabled builder.
- R4: After the highest enabled builder has served its group, selection wraps to the lowest enabled builder.
- R5: `cfg_group_i` = G gives G consecutive normal events to the same builder before it advances. G = 0 behaves as G = 1.
- R6: With `cfg_cal_en_i` = 1, an event whose `trg_type_i` equals the parameter `CAL_TYPE` (default 9) goes to builder `cfg_cal_idx_i`. The current builder and its event count are left unchanged, so the next normal event continues as if the calibration event had not occurred.
- R7: With `cfg_cal_en_i` = 0, a trigger of type `CAL_TYPE` takes part in the rotation like any other event.
- R8: An all-zero `cfg_mask_i` behaves as mask 0x0001, so only builder 0 is used.
- R9: When the effective mask differs from the one used by the previous normal event, the next normal event restarts at the lowest enabled builder of the new mask, with a fresh group count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mask_i | input | 16 | Builder enable mask, bit k enables builder k |
| cfg_group_i | input | 8 | Events per builder before advancing (0 acts as 1) |
| cfg_cal_idx_i | input | 4 | Builder used for calibration triggers |
| cfg_cal_en_i | input | 1 | Enables the fixed calibration builder |
| evt_accept_i | input | 1 | One-cycle strobe per accepted event |
| trg_type_i | input | 4 | Trigger type of the accepted event |
| eb_idx_o | output | 4 | Selected builder index, held until the next event |
| eb_vld_o | output | 1 | Pulses one cycle after each accepted event |

## Verification
The assertions check the following on every cycle:
- the valid pulse follows each accept by one cycle;
- the index holds between events;
- the calibration route leaves the rotation state untouched;
- every advance lands on an enabled builder;
- a held group repeats the current builder;
- an all-zero mask yields builder 0.

Some properties only the bench scenarios can show, because they depend on a whole sequence of events. These are the exact ascending visiting order, the wrap to the lowest builder, the group lengths including G = 0, the resumption of the rotation after calibration events, and the restart after a mask change in the middle of a group.

// File: rtl/eb_rr_pkg.sv
package eb_rr_pkg;
  // Action taken for the event in the current cycle
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_CAL  = 2'd1,
    ACT_STEP = 2'd2,
    ACT_HOLD = 2'd3
  } eb_act_e;
endpackage

// File: rtl/eb_pick.sv
module eb_pick #(
  parameter int unsigned NUM_EB = 16,
  localparam int unsigned IDX_W = $clog2(NUM_EB)
) (
  input  logic [NUM_EB-1:0] src_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o,
  output logic              higher_o,
  output logic [NUM_EB-1:0] rest_o
);
  logic [NUM_EB-1:0] at_or_below;

  // Lowest-index set bit
  always_comb begin
    idx_o = '0;
    hit_o = 1'b0;
    for (int k = NUM_EB-1; k >= 0; k--) begin
      if (src_i[k]) begin
        idx_o = IDX_W'(k);
        hit_o = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_EB; g++) begin : g_le
    assign at_or_below[g] = (IDX_W'(g) <= idx_o);
  end

  assign rest_o   = src_i & ~at_or_below;
  assign higher_o = |rest_o;
endmodule

// File: rtl/eb_group_cnt.sv
module eb_group_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_eff;

  assign lim_eff = (limit_i == '0) ? CNT_W'(1) : limit_i;
  assign done_o  = (cnt_q >= lim_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= CNT_W'(1);
    else if (step_i)    cnt_q <= cnt_q + CNT_W'(1);
  end

  // A hold step is only taken below the limit, so the count never wraps
  assert_cnt_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !restart_i |-> cnt_q != '1);
endmodule

// File: rtl/eb_rr_select.sv
module eb_rr_select
  import eb_rr_pkg::*;
#(
  parameter int unsigned NUM_EB   = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned TYPE_W   = 4,
  parameter logic [TYPE_W-1:0] CAL_TYPE = TYPE_W'(9),
  localparam int unsigned IDX_W   = $clog2(NUM_EB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EB-1:0] cfg_mask_i,
  input  logic [CNT_W-1:0]  cfg_group_i,
  input  logic [IDX_W-1:0]  cfg_cal_idx_i,
  input  logic              cfg_cal_en_i,
  input  logic              evt_accept_i,
  input  logic [TYPE_W-1:0] trg_type_i,
  output logic [IDX_W-1:0]  eb_idx_o,
  output logic              eb_vld_o
);
  localparam logic [NUM_EB-1:0] MASK_DEF = NUM_EB'(1);

  logic [NUM_EB-1:0] eff_mask, shadow_q, work_q, src, rest;
  logic [IDX_W-1:0]  cur_q, pick_idx;
  logic              fresh_q, mask_new, cal_hit, pick_hit, pick_higher, grp_done;
  eb_act_e           act;

  assign eff_mask = (|cfg_mask_i) ? cfg_mask_i : MASK_DEF;
  assign mask_new = fresh_q || (eff_mask != shadow_q);
  assign cal_hit  = cfg_cal_en_i && (trg_type_i == CAL_TYPE);
  assign src      = mask_new ? eff_mask : work_q;

  always_comb begin
    if (!evt_accept_i)           act = ACT_NONE;
    else if (cal_hit)            act = ACT_CAL;
    else if (mask_new || grp_done) act = ACT_STEP;
    else                         act = ACT_HOLD;
  end

  eb_pick #(.NUM_EB(NUM_EB)) i_pick (
    .src_i    (src),
    .idx_o    (pick_idx),
    .hit_o    (pick_hit),
    .higher_o (pick_higher),
    .rest_o   (rest)
  );

  eb_group_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (act == ACT_STEP),
    .step_i    (act == ACT_HOLD),
    .limit_i   (cfg_group_i),
    .done_o    (grp_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fresh_q  <= 1'b1;
      shadow_q <= MASK_DEF;
      work_q   <= MASK_DEF;
      cur_q    <= '0;
    end else if (act == ACT_STEP) begin
      fresh_q  <= 1'b0;
      shadow_q <= eff_mask;
      work_q   <= pick_higher ? rest : eff_mask;  // refill on wrap
      cur_q    <= pick_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eb_idx_o <= '0;
      eb_vld_o <= 1'b0;
    end else begin
      eb_vld_o <= evt_accept_i;
      unique case (act)
        ACT_CAL:  eb_idx_o <= cfg_cal_idx_i;
        ACT_STEP: eb_idx_o <= pick_idx;
        ACT_HOLD: eb_idx_o <= cur_q;
        default:  eb_idx_o <= eb_idx_o;
      endcase
    end
  end

  assert_vld_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_accept_i |=> eb_vld_o);
  assert_no_spurious_vld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_accept_i |=> !eb_vld_o && $stable(eb_idx_o));
  assert_pick_found_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == ACT_STEP |-> pick_hit && src[pick_idx]);
  assert_step_enabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == ACT_STEP |=> shadow_q[cur_q]);
  assert_hold_same_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == ACT_HOLD |=> eb_idx_o == $past(cur_q));
  assert_cal_route_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_accept_i && cal_hit |=> eb_idx_o == $past(cfg_cal_idx_i));
  assert_cal_keeps_state_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == ACT_CAL |=> $stable(work_q) && $stable(cur_q) && $stable(shadow_q));
  assert_zero_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_accept_i && !cal_hit && cfg_mask_i == '0 |=> eb_idx_o == '0);
endmodule

// File: tb/test_eb_rr_select.sv
`timescale 1ns/1ps
module test_eb_rr_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mask = 16'h0001;
  logic [7:0]  grp = 8'd1;
  logic [3:0]  cal_idx = 4'd0;
  logic        cal_en = 1'b0;
  logic        accept = 1'b0;
  logic [3:0]  ttype = 4'd0;
  logic [3:0]  idx;
  logic        vld;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit mon_en = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  // bench reference state
  bit         m_started = 0;
  logic [15:0] m_mask = 16'h0001;
  int         m_cur = 0;
  int         m_cnt = 0;
  logic [3:0] last_idx = 4'd0;

  always #2.5 clk = ~clk;

  eb_rr_select i_eb_rr_select (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mask_i(mask), .cfg_group_i(grp),
    .cfg_cal_idx_i(cal_idx), .cfg_cal_en_i(cal_en), .evt_accept_i(accept),
    .trg_type_i(ttype), .eb_idx_o(idx), .eb_vld_o(vld));

  function automatic int lowest(logic [15:0] m);
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int next_after(logic [15:0] m, int c);
    for (int i = c + 1; i < 16; i++) if (m[i]) return i;
    return lowest(m);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: one accepted event, expected builder pushed to the scoreboard
  task automatic send(logic [3:0] t, string tag);
    logic [15:0] em;
    int lim;
    int e;
    @(negedge clk);
    accept = 1'b1;
    ttype  = t;
    em  = (mask == 16'h0) ? 16'h0001 : mask;
    lim = (grp == 8'd0) ? 1 : int'(grp);
    if (cal_en && t == 4'd9) begin
      e = int'(cal_idx);
    end else begin
      if (!m_started || em != m_mask) begin
        m_cur = lowest(em); m_cnt = 1; m_started = 1; m_mask = em;
      end else if (m_cnt >= lim) begin
        m_cur = next_after(em, m_cur); m_cnt = 1;
      end else begin
        m_cnt++;
      end
      e = m_cur;
    end
    exp_q.push_back(4'(e));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      accept = 1'b0;
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (vld) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected valid", 1, 0);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(idx == e, t, idx, e);
        end
        last_idx = idx;
      end else begin
        check(idx == last_idx, "R2 index held", idx, last_idx);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(idx == 4'd0, "R1 index in reset", idx, 0);
    check(vld == 1'b0, "R1 valid in reset", vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(idx == 4'd0, "R1 index after reset", idx, 0);
    check(vld == 1'b0, "R1 valid after reset", vld, 0);
    mon_en = 1;

    // R3/R4: ascending order and wrap, group 1
    mask = 16'h00A5; grp = 8'd1;
    for (int i = 0; i < 6; i++) send(4'd1, "R3 R4 ascending with wrap");
    idle(3);

    // R5/R9: groups of 3, new mask restarts
    mask = 16'h8001; grp = 8'd3;
    for (int i = 0; i < 7; i++) send(4'd2, "R5 R9 group of three");
    idle(2);

    // R5: group 0 acts as 1
    mask = 16'h0006; grp = 8'd0;
    for (int i = 0; i < 3; i++) send(4'd3, "R5 group zero");
    idle(1);

    // R6: calibration override keeps rotation state
    grp = 8'd2; cal_en = 1'b1; cal_idx = 4'd11;
    send(4'd3, "R6 normal before cal");
    send(4'd9, "R6 cal routed");
    send(4'd3, "R6 normal after cal");
    send(4'd9, "R6 cal routed");
    send(4'd3, "R6 rotation resumed");
    send(4'd3, "R6 rotation resumed");
    idle(2);

    // R7: override disabled, calibration type rotates
    cal_en = 1'b0;
    for (int i = 0; i < 4; i++) send(4'd9, "R7 cal type in rotation");
    idle(2);

    // R8: zero mask uses builder 0
    mask = 16'h0000; grp = 8'd1;
    for (int i = 0; i < 3; i++) send(4'd4, "R8 zero mask");
    idle(1);

    // R9: mask rewritten in the middle of a group
    mask = 16'h00F0; grp = 8'd4;
    send(4'd5, "R9 first mask"); send(4'd5, "R9 first mask");
    idle(2);
    mask = 16'h00C0;
    for (int i = 0; i < 5; i++) send(4'd5, "R9 restart on new mask");
    idle(1);

    // R2: sparse events with gaps
    mask = 16'hFFFF; grp = 8'd1;
    for (int i = 0; i < 20; i++) begin
      send(4'd6, "R2 R3 sparse full mask");
      idle(i % 3);
    end
    idle(4);

    check(exp_q.size() == 0, "R2 all events answered", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule